// File: doc/BRIEF.md
# Reloadable Watchdog Countdown Timer

This block is a software-serviced watchdog. Software programs a 10-bit start value through a small register port. Any write to the reload address copies that start value into a down-counter. A free-running prescaler divides the system clock into a slow tick, and the counter drops by one on each tick. It counts only while the full-on power-state input is high. If software does not reload in time, the counter reaches zero. The block then raises a one-clock timeout pulse and sets a sticky timeout flag, which software clears by writing one to it.

A separate 8-bit scratch status register sits in the always-on domain. Its own reset input clears it, and it keeps its value when only the core reset is applied. Both reset inputs are asynchronous and active low. Each is released synchronously through a two-stage synchronizer.

The register port is a single-cycle write strobe with a 2-bit address, and reads are combinational from the address. The address map is:

| Address | Write | Read |
|---|---|---|
| 0 | start value | start value |
| 1 | any write reloads the counter | current count |
| 2 | status | status |
| 3 | clear the flag | timeout flag |

Top module: `wdt_top`

## Requirements
- R1: After core reset, the start-value register (address 0) reads 0x0004. Read bits 15:10 of address 0 are always zero, and write bits 15:10 have no effect on the stored value.
- R2: A write to address 0 whose bits 9:0 equal 0 or 1 is rejected and leaves the stored start value unchanged. Any other value of bits 9:0 is stored.
- R3: A write to address 1, with any data, loads the stored start value into the counter. Reading address 1 returns the counter in bits 9:0, with zeros above.
- R4: The prescaler runs freely and asserts a tick every PRESCALE clock cycles, whatever happens to the counter. The counter falls by exactly one per tick. After a reload with start value N, the timeout pulse appears between (N-1)*PRESCALE+1 and N*PRESCALE clock edges after the reload edge. This is the one-tick uncertainty.
- R5: While full_on is low, the counter holds its value and no timeout occurs.
- R6: When the counter steps from 1 to 0, timeout_pulse is high for exactly one clock and timeout_flag becomes 1 on the same edge. The counter then stays at 0 until the next reload.
- R7: timeout_flag is readable at address 3 bit 0. Writing 1 to bit 0 of address 3 clears it, and writing 0 there leaves it unchanged.
- R8: When a reload write and a tick land on the same clock edge, the counter takes the full start value and that tick is not applied.
- R9: The status register (address 2) is 8 bits read/write. Bits 15:8 read as zero. It resets to 0x00 only through aon_rst_n and keeps its contents across rst_n.
- R10: After core reset, the count is 0, timeout_flag is 0 and timeout_pulse is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Core reset, asynchronous active low |
| aon_rst_n | input | 1 | Always-on domain reset, asynchronous active low |
| full_on | input | 1 | High while the system is in its fully-on power state |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| addr | input | 2 | Register address (0 start value, 1 reload/count, 2 status, 3 flag) |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for the current address |
| timeout_pulse | output | 1 | One-clock pulse when the counter expires |
| timeout_flag | output | 1 | Sticky timeout indication |

## Verification
The assertions assume three things about the inputs. The write strobe lasts a single cycle per access. The address is stable while the strobe is high. The counter is changed only by a reload or a gated tick. Because the tick phase is not visible at the ports, the bench brackets expiry times by the one-tick window rather than exact edges. It finds the tick phase by watching the count step and then aligns a reload onto a tick edge. All stimulus changes on the falling clock edge, and writes are separated by idle cycles, so that every write is one clean strobe.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  // register address decode
  typedef enum logic [1:0] {
    WA_INIT   = 2'd0,
    WA_RELOAD = 2'd1,
    WA_STATUS = 2'd2,
    WA_FLAG   = 2'd3
  } wdt_addr_e;

  localparam int unsigned WDT_ADDR_W = 2;
  localparam int unsigned WDT_MIN_START = 2;

endpackage

// File: rtl/wdt_rst_sync.sv
module wdt_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign srst_n = sync_q;

endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int unsigned DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);

  generate
    if (DIV <= 1) begin : g_every
      assign tick = 1'b1;
    end else begin : g_div
      localparam int unsigned PW = $clog2(DIV);
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);

      logic [PW-1:0] phase_q;
      logic [PW-1:0] phase_d;
      logic          wrap;

      always_comb begin
        wrap    = (phase_q == LAST);
        phase_d = wrap ? '0 : phase_q + PW'(1);
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= '0;
        else        phase_q <= phase_d;
      end

      assign tick = wrap;

      // R4
      tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate

endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W     = 10,
  parameter int unsigned STAT_W    = 8,
  parameter int unsigned START_RST = 4
) (
  input  logic              clk,
  input  logic              core_rst_n,
  input  logic              aon_rst_n,
  input  logic              start_we,
  input  logic [CNT_W-1:0]  start_wdata,
  input  logic              stat_we,
  input  logic [STAT_W-1:0] stat_wdata,
  output logic [CNT_W-1:0]  start_val,
  output logic [STAT_W-1:0] status
);

  localparam logic [CNT_W-1:0] MIN_START = CNT_W'(WDT_MIN_START);
  localparam logic [CNT_W-1:0] RST_START = CNT_W'(START_RST);

  logic [CNT_W-1:0]  start_q;
  logic [STAT_W-1:0] stat_q;
  logic              start_en;
  logic              stat_en;

  // next-state: a start value below the minimum is dropped
  always_comb begin
    start_en = start_we && (start_wdata >= MIN_START);
    stat_en  = stat_we;
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n)   start_q <= RST_START;
    else if (start_en) start_q <= start_wdata;
  end

  // always-on domain: untouched by the core reset
  always_ff @(posedge clk or negedge aon_rst_n) begin
    if (!aon_rst_n)   stat_q <= '0;
    else if (stat_en) stat_q <= stat_wdata;
  end

  assign start_val = start_q;
  assign status    = stat_q;

  // R2
  start_floor_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    start_q >= MIN_START);

  // R2
  start_reject_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    (start_we && start_wdata < MIN_START) |=> start_q == $past(start_q));

  // R9
  stat_hold_chk: assert property (@(posedge clk) disable iff (!aon_rst_n)
    !stat_we |=> stat_q == $past(stat_q));

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reload,
  input  logic [CNT_W-1:0] start_val,
  input  logic             tick,
  input  logic             full_on,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] count,
  output logic             expire_pulse,
  output logic             expire_flag
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;
  logic             step;
  logic             expire;
  logic             pulse_q;
  logic             flag_q;
  logic             flag_d;

  // next-state: reload beats a coincident tick
  always_comb begin
    step   = tick && full_on && (cnt_q != '0) && !reload;
    expire = step && (cnt_q == ONE);
    cnt_en = reload || step;
    cnt_d  = reload ? start_val : (cnt_q - ONE);
    flag_d = expire || (flag_q && !flag_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= 1'b0;
      flag_q  <= 1'b0;
    end else begin
      pulse_q <= expire;
      flag_q  <= flag_d;
    end
  end

  assign count        = cnt_q;
  assign expire_pulse = pulse_q;
  assign expire_flag  = flag_q;

  // R8
  reload_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> cnt_q == $past(start_val));

  // R5
  power_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_on && !reload) |=> cnt_q == $past(cnt_q));

  // R4
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!reload && cnt_q != '0) |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) - ONE));

  // R6
  zero_stick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && !reload) |=> cnt_q == '0);

  // R6
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |=> !pulse_q);

  // R6
  pulse_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> (flag_q && cnt_q == '0));

  // R7
  flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !flag_clr) |=> flag_q);

endmodule

// File: rtl/wdt_top.sv
module wdt_top
  import wdt_pkg::*;
#(
  parameter int unsigned PRESCALE  = 60_000_000,
  parameter int unsigned CNT_W     = 10,
  parameter int unsigned STAT_W    = 8,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned START_RST = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              aon_rst_n,
  input  logic              full_on,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              timeout_pulse,
  output logic              timeout_flag
);

  localparam logic [CNT_W-1:0] MIN_START = CNT_W'(WDT_MIN_START);

  logic              core_rst_n;
  logic              aon_srst_n;
  logic              tick;
  logic              start_we;
  logic              stat_we;
  logic              reload;
  logic              flag_clr;
  logic [CNT_W-1:0]  start_val;
  logic [STAT_W-1:0] status;
  logic [CNT_W-1:0]  count;
  wdt_addr_e         sel;

  wdt_rst_sync u_core_sync (.clk(clk), .arst_n(rst_n),     .srst_n(core_rst_n));
  wdt_rst_sync u_aon_sync  (.clk(clk), .arst_n(aon_rst_n), .srst_n(aon_srst_n));

  // write decode
  always_comb begin
    sel      = wdt_addr_e'(addr);
    start_we = wr_en && (sel == WA_INIT);
    reload   = wr_en && (sel == WA_RELOAD);
    stat_we  = wr_en && (sel == WA_STATUS);
    flag_clr = wr_en && (sel == WA_FLAG) && wdata[0];
  end

  wdt_prescaler #(.DIV(PRESCALE)) u_presc (
    .clk  (clk),
    .rst_n(core_rst_n),
    .tick (tick)
  );

  wdt_regs #(.CNT_W(CNT_W), .STAT_W(STAT_W), .START_RST(START_RST)) u_regs (
    .clk        (clk),
    .core_rst_n (core_rst_n),
    .aon_rst_n  (aon_srst_n),
    .start_we   (start_we),
    .start_wdata(wdata[CNT_W-1:0]),
    .stat_we    (stat_we),
    .stat_wdata (wdata[STAT_W-1:0]),
    .start_val  (start_val),
    .status     (status)
  );

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk         (clk),
    .rst_n       (core_rst_n),
    .reload      (reload),
    .start_val   (start_val),
    .tick        (tick),
    .full_on     (full_on),
    .flag_clr    (flag_clr),
    .count       (count),
    .expire_pulse(timeout_pulse),
    .expire_flag (timeout_flag)
  );

  // read mux, zero-extended
  always_comb begin
    unique case (sel)
      WA_INIT:   rdata = DATA_W'(start_val);
      WA_RELOAD: rdata = DATA_W'(count);
      WA_STATUS: rdata = DATA_W'(status);
      default:   rdata = DATA_W'(timeout_flag);
    endcase
  end

  // R1
  upper_ignored_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    (start_we && wdata[DATA_W-1:CNT_W] != '0 && wdata[CNT_W-1:0] >= MIN_START)
      |=> start_val == $past(wdata[CNT_W-1:0]));

  // R3
  count_read_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    (sel == WA_RELOAD) |-> rdata[DATA_W-1:CNT_W] == '0);

endmodule

// File: tb/tb_wdt_top.sv
`timescale 1ns/1ps
module tb_wdt_top;

  localparam int P = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        aon_rst_n;
  logic        full_on;
  logic        wr_en;
  logic [1:0]  addr;
  logic [15:0] wdata;
  logic [15:0] rdata;
  logic        timeout_pulse;
  logic        timeout_flag;

  int total = 0;
  int bad   = 0;
  int pulses = 0;

  always #2.5 clk = ~clk;

  wdt_top #(.PRESCALE(P)) dut (
    .clk(clk), .rst_n(rst_n), .aon_rst_n(aon_rst_n), .full_on(full_on),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .timeout_pulse(timeout_pulse), .timeout_flag(timeout_flag)
  );

  always @(posedge clk) if (timeout_pulse === 1'b1) pulses <= pulses + 1;

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_rng(input string req, input int act, input int lo, input int hi);
    total++;
    if (act < lo || act > hi) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int d);
    @(negedge clk);
    addr = a;
    #1 d = int'(rdata);
  endtask

  task automatic apply_reset(input logic core, input logic aon);
    @(negedge clk);
    if (core) rst_n = 1'b0;
    if (aon)  aon_rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; aon_rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // reload with n, check expiry inside the one-tick window
  task automatic measure(input int n);
    int d;
    int p0;
    int v;
    wr(2'd0, 16'(n));
    wr(2'd3, 16'h0001);
    p0 = pulses;
    wr(2'd1, 16'h0000);
    d = 0;
    while (timeout_pulse !== 1'b1 && d < n * P + 10) begin
      @(negedge clk);
      d++;
    end
    check_rng("R4 expiry window", d, (n - 1) * P + 1, n * P);
    check("R6 flag with pulse", int'(timeout_flag), 1);
    @(negedge clk);
    check("R6 pulse width", int'(timeout_pulse), 0);
    repeat (2 * P) @(negedge clk);
    rd(2'd1, v);
    check("R6 count stays zero", v, 0);
    check("R6 single pulse", pulses - p0, 1);
  endtask

  initial begin
    #150000ns;
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int v;
    int held;
    int pv;
    int last;
    int cur;
    int idx;
    int guard;
    rst_n = 1'b0; aon_rst_n = 1'b0; full_on = 1'b1;
    wr_en = 1'b0; addr = 2'd0; wdata = '0;
    apply_reset(1'b1, 1'b1);

    // R10 / R1 / R9 reset state
    check("R10 pulse after reset", int'(timeout_pulse), 0);
    check("R10 flag after reset", int'(timeout_flag), 0);
    rd(2'd1, v); check("R10 count after reset", v, 0);
    rd(2'd0, v); check("R1 start reset value", v, 4);
    rd(2'd2, v); check("R9 status reset value", v, 0);
    repeat (3 * P) @(negedge clk);
    check("R10 no expiry when idle", pulses, 0);

    // R1 R2 sweep all 10-bit values with junk in bits 15:10
    held = 4;
    for (int s = 0; s < 1024; s++) begin
      wr(2'd0, {6'(s * 7 + 1), 10'(s)});
      if (s >= 2) held = s;
      rd(2'd0, v);
      check((s < 2) ? "R2 reject 0/1" : "R1 upper ignored / R2 store", v, held);
    end
    wr(2'd0, 16'h0000); rd(2'd0, v); check("R2 reject zero after 1023", v, 1023);
    wr(2'd0, 16'h0001); rd(2'd0, v); check("R2 reject one", v, 1023);

    // R9 status sweep
    for (int s = 0; s < 256; s++) begin
      wr(2'd2, {8'hFF, 8'(s)});
      rd(2'd2, v);
      check("R9 status rw", v, s);
    end

    // R3 reload copies start value
    wr(2'd0, 16'd300);
    full_on = 1'b0;
    wr(2'd1, 16'hBEEF);
    rd(2'd1, v); check("R3 reload load", v, 300);

    // R5 power gating holds the count
    repeat (6 * P) @(negedge clk);
    rd(2'd1, v); check("R5 hold while off", v, 300);
    check("R5 no pulse while off", pulses, 0);
    wr(2'd0, 16'd6); wr(2'd1, 16'h0000);
    repeat (8 * P) @(negedge clk);
    rd(2'd1, v); check("R5 hold short count", v, 6);
    check("R5 flag stays clear", int'(timeout_flag), 0);
    full_on = 1'b1;
    repeat (6 * P + 2) @(negedge clk);
    rd(2'd1, v); check("R5 resumes to zero", v, 0);
    check("R6 flag set", int'(timeout_flag), 1);

    // R7 flag clearing
    wr(2'd3, 16'hFFFE); rd(2'd3, v); check("R7 write 0 keeps flag", v, 1);
    wr(2'd3, 16'h0001); rd(2'd3, v); check("R7 write 1 clears flag", v, 0);

    // R4 exact tick period and single steps
    wr(2'd0, 16'd50); wr(2'd1, 16'h0000);
    addr = 2'd1; #1 pv = int'(rdata);
    last = -1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); #1 cur = int'(rdata);
      if (cur != pv) begin
        if (last >= 0) check("R4 tick period", i - last, P);
        check("R4 step by one", cur, pv - 1);
        last = i;
      end
      pv = cur;
    end

    // R8 reload lands on a tick edge
    guard = 0;
    idx = 0;
    while (idx == 0 && guard < 4 * P) begin
      @(negedge clk); #1 cur = int'(rdata);
      if (cur != pv) idx = 1;
      pv = cur;
      guard++;
    end
    check("R8 tick phase found", idx, 1);
    repeat (P - 1) @(negedge clk);
    wr_en = 1'b1; addr = 2'd1; wdata = 16'h0000;
    @(negedge clk); wr_en = 1'b0;
    #1 check("R8 reload beats tick", int'(rdata), 50);
    repeat (P) @(negedge clk);
    #1 check("R8 next tick applies", int'(rdata), 49);

    // R4 R6 expiry sweep
    for (int n = 2; n <= 40; n++) measure(n);
    measure(1023);

    // R9 core reset keeps status, aon reset clears it
    wr(2'd2, 16'h00A5);
    apply_reset(1'b1, 1'b0);
    rd(2'd2, v); check("R9 status kept over core reset", v, 8'hA5);
    rd(2'd0, v); check("R1 start value back to default", v, 4);
    rd(2'd1, v); check("R10 count cleared by core reset", v, 0);
    check("R10 flag cleared by core reset", int'(timeout_flag), 0);
    apply_reset(1'b0, 1'b1);
    rd(2'd2, v); check("R9 status cleared by aon reset", v, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule